// File: doc/BRIEF.md
# Write Completion Status Poller

After the host has told a flash device to program or erase, this block finds out when the device has finished. A one-cycle start pulse gives it the address to watch, the word that was written (or all ones for an erase) and a method select. From then on it reads that address over and over through a request/response read port and judges each returned word. In data-compare mode a read counts as complete when bit 7 of the word matches bit 7 of the expected word. In toggle mode a read counts as complete when bit 6 is the same as bit 6 of the read just before it. The internal operation finishes at a time the host cannot see, so a read can look complete while the device is still settling. For that reason one good-looking read is never accepted alone. Two more good reads must follow it back to back before the block reports done.

Polling does not run forever. Each run is limited to `MAX_POLLS` reads. If the last of those reads does not complete a confirmed run, the block raises a timeout. Done and timeout are single-cycle pulses, and in either case the block returns to idle.

The read request uses valid/ready. The block raises `rd_req_valid` and holds it and `rd_req_addr` steady until `rd_req_ready` is seen. It then raises `rd_rsp_ready` and waits for `rd_rsp_valid`. Only one read is ever outstanding. The responder may stall both phases for any number of cycles, and the block applies no timeout of its own to a single read. `rd_rsp_valid` while `rd_rsp_ready` is low has no effect.

Top module: `wcs_poller`

## Requirements
- R1: During reset and after it, `busy`, `rd_req_valid`, `rd_rsp_ready`, `done` and `timeout` are all low until a start is accepted.
- R2: A `start` pulse while idle captures address, expected word and mode (0 = data-compare, 1 = toggle), and the next cycle raises `rd_req_valid` with that address. A `start` while `busy` is high is ignored, and the address in use does not change.
- R3: At most one read is outstanding. `rd_rsp_ready` is raised only after a request handshake and lowered when the response is taken. `rd_req_valid` and `rd_rsp_ready` are never high together.
- R4: Once raised, `rd_req_valid` stays high and `rd_req_addr` stays stable until a cycle with `rd_req_ready` high.
- R5: In data-compare mode a read is good exactly when its bit 7 equals bit 7 of the expected word. All other bits, including bit 6, are ignored.
- R6: In toggle mode a read is good exactly when its bit 6 equals bit 6 of the previous read in the same run. The first read after a start is never good.
- R7: Done needs three good reads in a row: the apparent completion plus two confirming reads. Any read that is not good restarts the count from zero.
- R8: `done` pulses high for one cycle, in the cycle after the response that completes the run is taken. At the same time `busy` falls.
- R9: If read number `MAX_POLLS` (default 64) of a run does not produce done, `timeout` pulses for one cycle and the block returns to idle. When that last read does complete a confirmed run, done wins. `done` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_addr | input | AW | Location to poll |
| start_expect | input | DW | Word that was written (bit 7 used in data-compare mode) |
| start_mode | input | 1 | 0 = data-compare on bit 7, 1 = toggle on bit 6 |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Poller waiting for read data |
| rd_rsp_data | input | DW | Read data |
| busy | output | 1 | A poll run is in progress |
| done | output | 1 | One-cycle pulse: confirmed completion |
| timeout | output | 1 | One-cycle pulse: poll limit used up |

## Verification
The hardest cases to reach sit at the read limit: a confirmed run that ends on exactly the last permitted read, and a run that is one good read short when the limit hits. The stimulus gets there by scripting the response words: a counted stream of failing reads followed by good ones, placed so the third good read lands on read 64 or on read 65. Other scripts interrupt a run of good reads with one failure, and set bit 6 against bit 7 so that a mode watching the wrong bit would finish too early. The responder stalls both handshake phases on a fixed pattern. A second start is thrown in mid-run to show that it is ignored.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } mode_e;
endpackage

// File: rtl/wcs_eval.sv
module wcs_eval
  import wcs_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DP_BIT = 7,
  parameter int TG_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fire,
  input  mode_e         mode,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] expect_word,
  output logic          ok
);
  logic prev_bit_q;
  logic have_prev_q;

  always_comb begin
    if (mode == MODE_DATA) ok = (data[DP_BIT] == expect_word[DP_BIT]);
    else                   ok = have_prev_q && (data[TG_BIT] == prev_bit_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bit_q  <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
    end else if (fire) begin
      prev_bit_q  <= data[TG_BIT];
      have_prev_q <= 1'b1;
    end
  end

  AST_FIRST_TOGGLE_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_TOGGLE && !have_prev_q) |-> !ok); // R6
endmodule

// File: rtl/wcs_confirm.sv
module wcs_confirm #(
  parameter int CONFIRM_READS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  input  logic ok,
  output logic confirmed
);
  localparam int RW = $clog2(CONFIRM_READS + 1);
  logic [RW-1:0] run_q;

  assign confirmed = fire && ok && (run_q == RW'(CONFIRM_READS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear)   run_q <= '0;
    else if (fire) begin
      if (!ok)             run_q <= '0;
      else if (!confirmed) run_q <= run_q + 1'b1;
    end
  end

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ok && !clear) |=> (run_q == '0)); // R7
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(CONFIRM_READS)); // R7
endmodule

// File: rtl/wcs_limit.sv
module wcs_limit #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt_q;

  assign last = fire && (cnt_q == CW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (fire && cnt_q != CW'(MAX_POLLS)) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_POLLS)); // R9
endmodule

// File: rtl/wcs_poller.sv
module wcs_poller
  import wcs_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int MAX_POLLS     = 64,
  parameter int CONFIRM_READS = 2,
  parameter int DP_BIT        = 7,
  parameter int TG_BIT        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_expect,
  input  logic          start_mode,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          busy,
  output logic          done,
  output logic          timeout
);
  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  mode_e         mode_q;
  logic          start_fire, rsp_fire, ok, confirmed, last;

  assign start_fire   = (st_q == ST_IDLE) && start;
  assign rsp_fire     = (st_q == ST_WAIT) && rd_rsp_valid;
  assign rd_req_valid = (st_q == ST_REQ);
  assign rd_rsp_ready = (st_q == ST_WAIT);
  assign rd_req_addr  = addr_q;
  assign busy         = (st_q != ST_IDLE);

  wcs_eval #(.DW(DW), .DP_BIT(DP_BIT), .TG_BIT(TG_BIT)) u_eval (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .fire(rsp_fire),
    .mode(mode_q), .data(rd_rsp_data), .expect_word(exp_q), .ok(ok));

  wcs_confirm #(.CONFIRM_READS(CONFIRM_READS)) u_confirm (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .fire(rsp_fire),
    .ok(ok), .confirmed(confirmed));

  wcs_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .fire(rsp_fire),
    .last(last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= '0;
      mode_q  <= MODE_DATA;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_fire) begin
          addr_q <= start_addr;
          exp_q  <= start_expect;
          mode_q <= mode_e'(start_mode);
          st_q   <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_fire) begin
          if (confirmed) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else if (last) begin
            timeout <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_rsp_ready) |-> $past(rd_req_valid && rd_req_ready)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rd_req_addr)); // R2
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_rsp_valid && rd_rsp_ready)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done)); // R8
  AST_DONE_TO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R9
endmodule

// File: tb/wcs_poller_test.sv
module wcs_poller_test;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LIMIT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_expect = '0;
  logic start_mode = 1'b0;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic [DW-1:0] rd_rsp_data;
  logic busy, done, timeout;

  always #10 clk = ~clk;

  wcs_poller uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_expect(start_expect), .start_mode(start_mode),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .timeout(timeout));

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  int m_state = 0;
  int m_addr = 0, m_exp = 0, m_mode = 0, m_cnt = 0, m_run = 0, m_prev = 0, m_have = 0;
  bit m_done = 0, m_to = 0;
  // responder
  logic [DW-1:0] q[$];
  bit rsp_pend = 0;
  int lat = 0;
  // stimulus request
  bit want_start = 0;
  int want_addr = 0, want_exp = 0, want_mode = 0;
  // port-level observations per run
  int seen_reads = 0;
  bit seen_done = 0, seen_to = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit rv;
    logic [DW-1:0] rd;
    bit good;
    @(negedge clk);
    cyc++;
    // compare outputs with model
    chk("R2", "busy", busy, m_state != 0);
    chk("R4", "rd_req_valid", rd_req_valid, m_state == 1);
    if (m_state == 1) chk("R2", "rd_req_addr", rd_req_addr, m_addr);
    chk("R3", "rd_rsp_ready", rd_rsp_ready, m_state == 2);
    chk("R8", "done", done, m_done);
    chk("R9", "timeout", timeout, m_to);
    if (done) seen_done = 1;
    if (timeout) seen_to = 1;
    // drive inputs for the coming edge
    start        = want_start;
    start_addr   = AW'(want_addr);
    start_expect = DW'(want_exp);
    start_mode   = want_mode[0];
    want_start   = 0;
    rd_req_ready = (cyc % 3) != 1;
    rv = rsp_pend && lat == 0;
    rd = (q.size() > 0) ? q[0] : '0;
    rd_rsp_valid = rv;
    rd_rsp_data  = rv ? rd : 16'hdead;
    // advance responder and model
    m_done = 0;
    m_to = 0;
    if (rsp_pend && lat > 0) lat--;
    case (m_state)
      0: if (start) begin
        m_addr = int'(start_addr); m_exp = int'(start_expect); m_mode = start_mode;
        m_cnt = 0; m_run = 0; m_have = 0; m_state = 1;
      end
      1: if (rd_req_ready) begin
        m_state = 2; rsp_pend = 1; lat = 2;
      end
      2: if (rv) begin
        rsp_pend = 0;
        if (q.size() > 0) void'(q.pop_front());
        seen_reads++;
        if (m_mode == 0) good = rd[7] == m_exp[7];
        else good = m_have && (int'(rd[6]) == m_prev);
        m_prev = rd[6]; m_have = 1; m_cnt++;
        if (good) m_run++; else m_run = 0;
        if (m_run == 3) begin m_done = 1; m_state = 0; end
        else if (m_cnt == LIMIT) begin m_to = 1; m_state = 0; end
        else m_state = 1;
      end
      default: m_state = 0;
    endcase
  endtask

  task automatic run(input string req, input int addr, input int exp, input int mode,
                     input bit exp_done, input int exp_reads, input bit poke_busy);
    int n = 0;
    seen_reads = 0; seen_done = 0; seen_to = 0;
    want_start = 1; want_addr = addr; want_exp = exp; want_mode = mode;
    step();
    step();
    while ((m_state != 0 || m_done || m_to) && n < 3000) begin
      if (poke_busy && n == 5) begin
        want_start = 1; want_addr = addr ^ 'h0f0f0; want_exp = ~exp; want_mode = 1 - mode;
      end
      step();
      n++;
    end
    step();
    if (n >= 3000) chk(req, "run finished", 0, 1);
    chk(req, "done seen", seen_done, exp_done);
    chk(req, "timeout seen", seen_to, !exp_done);
    chk(req, "reads used", seen_reads, exp_reads);
    q.delete();
  endtask

  initial begin
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "req in reset", rd_req_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "req after reset", rd_req_valid, 0);
    chk("R1", "rsp_ready after reset", rd_rsp_ready, 0);
    chk("R1", "done/timeout after reset", {done, timeout}, 0);
    repeat (4) step();

    // R5/R7: data-compare, run broken by one failing read, second start ignored (R2)
    q = '{16'h0000, 16'h0000, 16'h0080, 16'h0000, 16'h0080, 16'h0080, 16'h0080};
    run("R7", 'h12345, 'h0080, 0, 1, 7, 1);
    // R5: bit 6 ignored in data-compare mode, bit 7 expected low
    q = '{16'h0040, 16'h00c0, 16'h0040, 16'h0000, 16'h0040};
    run("R5", 'h00abc, 'h0000, 0, 1, 5, 0);
    // R5: bits other than 7 differ, still good
    q = '{16'hffff, 16'h0080, 16'h7f80};
    run("R5", 'h00001, 'h0080, 0, 1, 3, 0);
    // R6: toggling then steady
    q = '{16'h0040, 16'h0000, 16'h0040, 16'h0040, 16'h0040, 16'h0040};
    run("R6", 'h55555, 'h0000, 1, 1, 6, 0);
    // R6: steady from the first read, first read never counts
    q = '{16'h0000, 16'h0080, 16'h0000, 16'h0080};
    run("R6", 'h2aaaa, 'h0080, 1, 1, 4, 1);
    // R9: data-compare never completes
    run("R9", 'h00010, 'h0080, 0, 0, LIMIT, 0);
    // R9: toggle forever
    for (int i = 0; i < LIMIT; i++) q.push_back((i % 2) ? 16'h0040 : 16'h0000);
    run("R9", 'h00020, 'h0000, 1, 0, LIMIT, 0);
    // R9: confirmed run ends on the last permitted read -> done wins
    for (int i = 0; i < LIMIT - 3; i++) q.push_back(16'h0000);
    repeat (3) q.push_back(16'h0080);
    run("R9", 'h00030, 'h0080, 0, 1, LIMIT, 0);
    // R9: one good read short at the limit -> timeout
    for (int i = 0; i < LIMIT - 2; i++) q.push_back(16'h0000);
    repeat (3) q.push_back(16'h0080);
    run("R9", 'h00040, 'h0080, 0, 0, LIMIT, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule